// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller of an integrating analog-to-digital converter. The integrator, its input and reference switches and the zero-crossing comparator are outside it. The controller repeats a fixed measurement cycle with three phases. First comes an auto-zero interval that nulls the integrator. Next the unknown input is integrated for a fixed number of clocks. Last, a reference of the opposite sign drives the integrator back to zero. Each phase has its own switch-select output, and exactly one of them is high at any time. A separate output selects the sign of the reference.

One shared counter times the auto-zero and signal phases and measures the length of the de-integration phase. The comparator level at the last signal-integration clock gives the input's sign. That sign also sets the reference polarity. De-integration stops on the first clock at which the comparator shows the opposite level. The number of clocks counted up to that point is the magnitude of the result. If no crossing arrives within the allowed window, the magnitude saturates and an overrange flag is raised. The magnitude, the sign and the overrange flag are loaded together with a one-cycle done strobe. Afterwards the sequencer either starts the next auto-zero at once (free-run) or holds the integrator at zero until the next start request.

Top module: `dslope_seq`

## Requirements
- R1: While rst_n is low, sw_az is 1, sw_sig, sw_ref and done are 0, and result, sign and overrange are 0.
- R2: In every cycle exactly one of sw_az, sw_sig and sw_ref is 1.
- R3: After reset release, or on entry to auto-zero, sw_az stays high for exactly AZ_LEN cycles, and then sw_sig goes high.
- R4: sw_sig stays high for exactly SIG_LEN cycles, and then sw_ref goes high.
- R5: The comparator level sampled at the clock edge that ends the last signal-integration cycle is the sign of the conversion (1 = positive input). While sw_ref is high, ref_neg equals that sign, so ref_neg=1 applies the negative reference.
- R6: De-integration ends in the first sw_ref cycle k (counting from 0) in which cmp differs from the sign. The result is then k, for any k from 0 to MAX_DEINT-1.
- R7: If cmp still equals the sign in sw_ref cycle MAX_DEINT-1, de-integration ends there with result = MAX_DEINT and overrange = 1. Otherwise overrange is 0.
- R8: done is 1 for exactly the one cycle that follows the last sw_ref cycle. result, sign and overrange take their new values in that same cycle and do not change at any other time.
- R9: With free_run=1, sw_az follows the done cycle at once and a new auto-zero of AZ_LEN cycles starts. With free_run=0, sw_az stays high until start is 1 at a clock edge, and auto-zero counting starts from that edge. A start seen in any other phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; it asserts asynchronously and must be released synchronously to clk |
| start | input | 1 | Request to begin a conversion while the sequencer is holding |
| free_run | input | 1 | 1: start each conversion right after the previous one ends |
| cmp | input | 1 | Comparator output, 1 when the integrator is on the positive side of zero |
| sw_az | output | 1 | Auto-zero switch select |
| sw_sig | output | 1 | Signal-integration switch select |
| sw_ref | output | 1 | Reference de-integration switch select |
| ref_neg | output | 1 | Reference polarity select, 1 = negative reference |
| result | output | $clog2(MAX_DEINT+1) | De-integration count of the last conversion |
| sign | output | 1 | Sign of the last conversion, 1 = positive |
| overrange | output | 1 | The last conversion saturated at MAX_DEINT |
| done | output | 1 | One-cycle strobe when a new result is loaded |

## Verification
Every phase select is registered, so it changes in the cycle after the clock edge that ends the previous phase. The comparator level that ends de-integration shows up one cycle later as done, together with the new result, sign and overrange. The bench drives cmp on the falling edge from its own count of sw_ref cycles, which sets the crossing cycle of each conversion exactly. A behavioural model that advances on each rising edge predicts every output, and the outputs are compared on each falling edge, so every compare sees values that have settled one full register stage after the edge that caused them.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_SIG   = 2'd1,
    PH_DEINT = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;
endpackage

// File: rtl/dslope_timer.sv
module dslope_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] q
);
  logic [CW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)     q_nxt = '0;
    else if (en) q_nxt = q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int AZ_LEN    = 1000,
  parameter int SIG_LEN   = 1000,
  parameter int MAX_DEINT = 2000,
  parameter int CW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          free_run,
  input  logic          cmp,
  input  logic [CW-1:0] cnt,
  output phase_e        phase,
  output logic          pol,
  output logic          cnt_clr,
  output logic          cnt_en,
  output logic          fin,
  output logic          fin_ovr
);
  localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_LEN - 1);
  localparam logic [CW-1:0] SIG_LAST = CW'(SIG_LEN - 1);
  localparam logic [CW-1:0] DE_LAST  = CW'(MAX_DEINT - 1);

  phase_e phase_nxt;
  logic   pol_nxt;
  logic   pol_ld;

  always_comb begin
    phase_nxt = phase;
    cnt_clr   = 1'b0;
    cnt_en    = 1'b0;
    pol_ld    = 1'b0;
    fin       = 1'b0;
    fin_ovr   = 1'b0;
    unique case (phase)
      PH_AZ: begin
        if (cnt == AZ_LAST) begin
          phase_nxt = PH_SIG;
          cnt_clr   = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      PH_SIG: begin
        if (cnt == SIG_LAST) begin
          phase_nxt = PH_DEINT;
          cnt_clr   = 1'b1;
          pol_ld    = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      PH_DEINT: begin
        if (cmp != pol) begin
          fin = 1'b1;
        end else if (cnt == DE_LAST) begin
          fin     = 1'b1;
          fin_ovr = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
        if (fin) begin
          phase_nxt = free_run ? PH_AZ : PH_HOLD;
          cnt_clr   = 1'b1;
        end
      end
      PH_HOLD: begin
        if (start) begin
          phase_nxt = PH_AZ;
          cnt_clr   = 1'b1;
        end
      end
      default: begin
        phase_nxt = PH_AZ;
        cnt_clr   = 1'b1;
      end
    endcase
  end

  always_comb begin
    pol_nxt = pol;
    if (pol_ld) pol_nxt = cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_AZ;
      pol   <= 1'b0;
    end else begin
      phase <= phase_nxt;
      pol   <= pol_nxt;
    end
  end
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
  parameter int MAX_DEINT = 2000,
  parameter int CW        = 11,
  parameter int RW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin,
  input  logic          fin_ovr,
  input  logic          pol,
  input  logic [CW-1:0] cnt,
  output logic [RW-1:0] result,
  output logic          sign,
  output logic          overrange,
  output logic          done
);
  localparam logic [RW-1:0] SAT = RW'(MAX_DEINT);

  logic [RW-1:0] result_nxt;
  logic          sign_nxt;
  logic          ovr_nxt;

  always_comb begin
    result_nxt = result;
    sign_nxt   = sign;
    ovr_nxt    = overrange;
    if (fin) begin
      result_nxt = fin_ovr ? SAT : RW'(cnt);
      sign_nxt   = pol;
      ovr_nxt    = fin_ovr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      sign      <= 1'b0;
      overrange <= 1'b0;
      done      <= 1'b0;
    end else begin
      result    <= result_nxt;
      sign      <= sign_nxt;
      overrange <= ovr_nxt;
      done      <= fin;
    end
  end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int AZ_LEN    = 1000,
  parameter int SIG_LEN   = 1000,
  parameter int MAX_DEINT = 2000,
  localparam int RW       = $clog2(MAX_DEINT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          free_run,
  input  logic          cmp,
  output logic          sw_az,
  output logic          sw_sig,
  output logic          sw_ref,
  output logic          ref_neg,
  output logic [RW-1:0] result,
  output logic          sign,
  output logic          overrange,
  output logic          done
);
  localparam int LEN_A   = (AZ_LEN > SIG_LEN) ? AZ_LEN : SIG_LEN;
  localparam int LONGEST = (LEN_A > MAX_DEINT) ? LEN_A : MAX_DEINT;
  localparam int CW      = $clog2(LONGEST + 1);

  phase_e        phase;
  logic          pol;
  logic          cnt_clr;
  logic          cnt_en;
  logic          fin;
  logic          fin_ovr;
  logic [CW-1:0] cnt;

  dslope_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .q     (cnt)
  );

  dslope_fsm #(
    .AZ_LEN    (AZ_LEN),
    .SIG_LEN   (SIG_LEN),
    .MAX_DEINT (MAX_DEINT),
    .CW        (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .free_run (free_run),
    .cmp      (cmp),
    .cnt      (cnt),
    .phase    (phase),
    .pol      (pol),
    .cnt_clr  (cnt_clr),
    .cnt_en   (cnt_en),
    .fin      (fin),
    .fin_ovr  (fin_ovr)
  );

  dslope_result #(
    .MAX_DEINT (MAX_DEINT),
    .CW        (CW),
    .RW        (RW)
  ) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin       (fin),
    .fin_ovr   (fin_ovr),
    .pol       (pol),
    .cnt       (cnt),
    .result    (result),
    .sign      (sign),
    .overrange (overrange),
    .done      (done)
  );

  // the hold phase keeps the integrator shorted, like auto-zero
  assign sw_az   = (phase == PH_AZ) || (phase == PH_HOLD);
  assign sw_sig  = (phase == PH_SIG);
  assign sw_ref  = (phase == PH_DEINT);
  assign ref_neg = pol;
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int MAX_DEINT = 2000,
  localparam int RW       = $clog2(MAX_DEINT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_az,
  input logic          sw_sig,
  input logic          sw_ref,
  input logic          ref_neg,
  input logic [RW-1:0] result,
  input logic          overrange,
  input logic          done
);
  p_one_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_az, sw_sig, sw_ref}) == 1);

  p_az_to_sig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_az) |-> sw_sig);

  p_sig_to_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_sig) |-> sw_ref);

  p_pol_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ref && $past(sw_ref)) |-> $stable(ref_neg));

  p_ovr_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overrange) |-> (result == RW'(MAX_DEINT)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(sw_ref) && !sw_ref));

  p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind dslope_seq dslope_seq_chk #(.MAX_DEINT(MAX_DEINT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_az     (sw_az),
  .sw_sig    (sw_sig),
  .sw_ref    (sw_ref),
  .ref_neg   (ref_neg),
  .result    (result),
  .overrange (overrange),
  .done      (done)
);

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
  localparam int AZ  = 8;
  localparam int SG  = 10;
  localparam int MX  = 20;
  localparam int RW  = $clog2(MX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic free_run = 1'b1;
  logic cmp = 1'b0;
  logic sw_az, sw_sig, sw_ref, ref_neg, sign, overrange, done;
  logic [RW-1:0] result;

  int checks = 0;
  int errors = 0;
  int tgt_n = 5;
  bit tgt_p = 1'b1;
  int kref = 0;

  // behavioural model state: 0 auto-zero, 1 signal, 2 de-integrate, 3 hold
  int mph, mcnt, e_res;
  bit mpol, e_sign, e_ovr, e_done;

  always #5 clk = ~clk;

  dslope_seq #(.AZ_LEN(AZ), .SIG_LEN(SG), .MAX_DEINT(MX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .free_run(free_run), .cmp(cmp),
    .sw_az(sw_az), .sw_sig(sw_sig), .sw_ref(sw_ref), .ref_neg(ref_neg),
    .result(result), .sign(sign), .overrange(overrange), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = 0; mcnt = 0; mpol = 0; e_res = 0; e_sign = 0; e_ovr = 0; e_done = 0;
    end else begin
      e_done = 0;
      case (mph)
        0: if (mcnt == AZ - 1) begin mph = 1; mcnt = 0; end else mcnt++;
        1: if (mcnt == SG - 1) begin mpol = cmp; mph = 2; mcnt = 0; end else mcnt++;
        2: begin
          if (cmp != mpol || mcnt == MX - 1) begin
            e_ovr  = (cmp == mpol);
            e_res  = e_ovr ? MX : mcnt;
            e_sign = mpol;
            e_done = 1;
            mph    = free_run ? 0 : 3;
            mcnt   = 0;
          end else mcnt++;
        end
        default: if (start) begin mph = 0; mcnt = 0; end
      endcase
    end
  end

  // comparator stimulus: stays on the input's side for tgt_n de-integration cycles
  always @(negedge clk) begin
    if (sw_ref) begin
      cmp <= (kref < tgt_n) ? tgt_p : ~tgt_p;
      kref <= kref + 1;
    end else begin
      cmp <= tgt_p;
      kref <= 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sw_az == (mph == 0 || mph == 3), "R3/R9 sw_az", sw_az, (mph == 0 || mph == 3));
      chk(sw_sig == (mph == 1), "R4 sw_sig", sw_sig, mph == 1);
      chk(sw_ref == (mph == 2), "R6 sw_ref", sw_ref, mph == 2);
      chk((sw_az + sw_sig + sw_ref) == 1, "R2 one-hot", sw_az + sw_sig + sw_ref, 1);
      if (mph == 2) chk(ref_neg == mpol, "R5 ref_neg", ref_neg, mpol);
      chk(done == e_done, "R8 done", done, e_done);
      chk(int'(result) == e_res, "R6 result", result, e_res);
      chk(sign == e_sign, "R5 sign", sign, e_sign);
      chk(overrange == e_ovr, "R7 overrange", overrange, e_ovr);
    end
  end

  task automatic check_reset();
    chk(sw_az == 1 && sw_sig == 0 && sw_ref == 0, "R1 switches", {sw_az, sw_sig, sw_ref}, 3'b100);
    chk(result == 0 && sign == 0 && overrange == 0 && done == 0, "R1 outputs",
        {result, sign, overrange, done}, 0);
  endtask

  task automatic run_conv(input int n, input bit p);
    int exp_r;
    tgt_n = n;
    tgt_p = p;
    exp_r = (n >= MX) ? MX : n;
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(int'(result) == exp_r, "R6/R7 conversion count", result, exp_r);
    chk(overrange == (n >= MX), "R7 flag", overrange, n >= MX);
    chk(sign == p, "R5 latched sign", sign, p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    run_conv(5, 1'b1);
    run_conv(0, 1'b0);
    run_conv(MX - 1, 1'b1);
    run_conv(MX, 1'b0);
    run_conv(MX + 10, 1'b1);
    free_run = 1'b0;
    run_conv(7, 1'b0);
    repeat (12) @(negedge clk);
    chk(sw_az == 1 && done == 0, "R9 holding", sw_az, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;  // during auto-zero: ignored
    run_conv(3, 1'b1);
    free_run = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    run_conv(4, 1'b0);
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    run_conv(11, 1'b0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule